// File: doc/BRIEF.md
# Leaf page-entry access guard

This block decides whether an access may use a leaf page-table entry. It is the checking stage that sits beside a page walker and a translation cache. It takes the low flag byte of the entry, the kind of access (read, write or execute), whether the access is an instruction fetch or a data access, the current privilege, and the machine status bits that affect translation. From these it returns the privilege the access is judged at, whether translation applies, whether the entry is malformed, and whether the access is allowed. All of these outputs are combinational.

The block also holds the translation control register. A write to that register passes through a legalisation rule: a write that selects a scheme the block does not support leaves the old value in place. The register's mode field decides whether accesses below machine level are translated. Its other fields (address-space tag and root page number) are stored as written and are not used here.

Top module: `pte_guard`

## Requirements
- R1: `pte_invalid` is 1 exactly when flag bit 0 (valid) is 0, or when flag bit 2 (write) is 1 while flag bit 1 (read) is 0.
- R2: Privilege encoding is 0 = user, 1 = supervisor, 3 = machine. `eff_priv` equals `cur_priv` for a fetch (`is_fetch`=1). For a data access it equals `mpp` when `mprv` is 1, and `cur_priv` otherwise.
- R3: `xlate_on` is 1 exactly when `eff_priv` is not 3 and the stored mode field `satp_q[63:60]` is 8. Otherwise the address passes through untranslated.
- R4: `satp_q` resets to 0. A write with mode code 0 or 8 in bits 63:60 stores the whole word at the next clock edge. A write with code 1 (the 32-bit scheme) or any other code leaves `satp_q` unchanged.
- R5: With translation on and user privilege, a read (`acc_type`=0) is allowed only if flag bit 4 (user) is 1, and either flag bit 1 is 1 or both flag bit 3 (execute) and `mxr` are 1.
- R6: With translation on and user privilege, a write (`acc_type`=1) is allowed only if flag bits 4 and 2 are both 1.
- R7: With translation on and user privilege, an execute (`acc_type`=2) is allowed only if flag bits 4 and 3 are both 1.
- R8: With translation on and supervisor privilege on a page with flag bit 4 set, an execute is always denied. A read or write is allowed only when `sum` is 1 and the read rule of R5 or the write rule of R6 (without the user test) is met.
- R9: With translation on and supervisor privilege on a page with flag bit 4 clear, read, write and execute follow the R5/R6/R7 rules without the user test.
- R10: `perm_ok` is 1 whenever `xlate_on` is 0. With translation on, `acc_type`=3 and the reserved privilege 2 are always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| satp_wr_en | input | 1 | Write strobe for the translation control register |
| satp_wr_data | input | SATP_W | Proposed register value, mode in the top four bits |
| satp_q | output | SATP_W | Current register value |
| pte_flags | input | 8 | Leaf entry flags: V0 R1 W2 X3 U4 G5 A6 D7 |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| cur_priv | input | 2 | Current privilege |
| mprv | input | 1 | Data accesses use the privilege in `mpp` |
| mpp | input | 2 | Previous privilege field |
| mxr | input | 1 | Reads may use execute-only pages |
| sum | input | 1 | Supervisor may touch user pages |
| eff_priv | output | 2 | Privilege the access is judged at |
| xlate_on | output | 1 | 1 when the 39-bit scheme applies |
| pte_invalid | output | 1 | Entry flag combination is malformed |
| perm_ok | output | 1 | Access allowed |

## Verification
A register write and a permission check can fall in the same cycle. The check must then still use the old mode, and the new mode only from the following cycle. The bench provokes this by driving random control-register writes, with codes 0, 1, 8 and others, in the same cycles as random check vectors. It judges each vector against the mode its model held before that edge, and compares `satp_q` after the edge. A second overlap is between the `mprv` redirect and instruction fetches. The bench drives fetches with `mprv` set and expects the redirect to have no effect on them.

// File: rtl/pte_guard_pkg.sv
package pte_guard_pkg;

  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_BARE = 4'd0;
  localparam logic [MODE_W-1:0] MODE_PG32 = 4'd1;
  localparam logic [MODE_W-1:0] MODE_PG39 = 4'd8;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  // flag byte, bit 0 is valid
  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } flags_t;

  // only bare and the 39-bit scheme are kept; the 32-bit one is refused
  function automatic logic mode_accepted(input logic [MODE_W-1:0] m);
    return (m == MODE_BARE) || (m == MODE_PG39);
  endfunction

  function automatic logic flags_malformed(input flags_t f);
    return !f.v || (f.w && !f.r);
  endfunction

  function automatic priv_e pick_priv(input logic fetch, input priv_e cur,
                                      input logic redirect, input priv_e prev);
    return (!fetch && redirect) ? prev : cur;
  endfunction

  // the flag demand of an access, ignoring the user bit
  function automatic logic kind_allowed(input acc_e a, input logic mxr, input flags_t f);
    logic ok;
    case (a)
      ACC_RD:  ok = f.r || (f.x && mxr);
      ACC_WR:  ok = f.w;
      ACC_EX:  ok = f.x;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic leaf_allows(input acc_e a, input priv_e p, input logic mxr,
                                       input logic sum, input flags_t f);
    logic base;
    logic ok;
    base = kind_allowed(a, mxr, f);
    case (p)
      PRIV_U:  ok = f.u && base;
      PRIV_S:  ok = f.u ? ((a != ACC_EX) && sum && base) : base;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pte_guard_ctl.sv
module pte_guard_ctl
  import pte_guard_pkg::*;
#(
  parameter int SATP_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SATP_W-1:0] wr_data,
  output logic [SATP_W-1:0] ctl_q,
  output logic              wr_taken
);
  localparam int MODE_LSB = SATP_W - MODE_W;

  logic [MODE_W-1:0] wr_mode;
  assign wr_mode  = wr_data[MODE_LSB +: MODE_W];
  assign wr_taken = wr_en && mode_accepted(wr_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_taken) ctl_q <= wr_data;
  end
endmodule

// File: rtl/pte_guard_priv.sv
module pte_guard_priv
  import pte_guard_pkg::*;
(
  input  logic              is_fetch,
  input  logic [1:0]        cur_priv,
  input  logic              mprv,
  input  logic [1:0]        mpp,
  input  logic [MODE_W-1:0] ctl_mode,
  output logic [1:0]        eff_priv,
  output logic              xlate_on
);
  priv_e ep;
  assign ep       = pick_priv(is_fetch, priv_e'(cur_priv), mprv, priv_e'(mpp));
  assign eff_priv = ep;
  assign xlate_on = (ep != PRIV_M) && (ctl_mode == MODE_PG39);
endmodule

// File: rtl/pte_guard_perm.sv
module pte_guard_perm
  import pte_guard_pkg::*;
(
  input  logic [7:0] flags,
  input  logic [1:0] acc_type,
  input  logic [1:0] priv,
  input  logic       mxr,
  input  logic       sum,
  input  logic       xlate_on,
  output logic       leaf_ok,
  output logic       pte_invalid,
  output logic       perm_ok
);
  flags_t f;
  assign f           = flags_t'(flags);
  assign pte_invalid = flags_malformed(f);
  assign leaf_ok     = leaf_allows(acc_e'(acc_type), priv_e'(priv), mxr, sum, f);
  assign perm_ok     = xlate_on ? leaf_ok : 1'b1;
endmodule

// File: rtl/pte_guard.sv
module pte_guard
  import pte_guard_pkg::*;
#(
  parameter int SATP_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              satp_wr_en,
  input  logic [SATP_W-1:0] satp_wr_data,
  output logic [SATP_W-1:0] satp_q,
  input  logic [7:0]        pte_flags,
  input  logic [1:0]        acc_type,
  input  logic              is_fetch,
  input  logic [1:0]        cur_priv,
  input  logic              mprv,
  input  logic [1:0]        mpp,
  input  logic              mxr,
  input  logic              sum,
  output logic [1:0]        eff_priv,
  output logic              xlate_on,
  output logic              pte_invalid,
  output logic              perm_ok
);
  localparam int MODE_LSB = SATP_W - MODE_W;

  logic              wr_taken;
  logic              leaf_ok;
  logic [MODE_W-1:0] ctl_mode;

  pte_guard_ctl #(.SATP_W(SATP_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(satp_wr_en), .wr_data(satp_wr_data),
    .ctl_q(satp_q), .wr_taken(wr_taken)
  );

  assign ctl_mode = satp_q[MODE_LSB +: MODE_W];

  pte_guard_priv u_priv (
    .is_fetch(is_fetch), .cur_priv(cur_priv), .mprv(mprv), .mpp(mpp),
    .ctl_mode(ctl_mode), .eff_priv(eff_priv), .xlate_on(xlate_on)
  );

  pte_guard_perm u_perm (
    .flags(pte_flags), .acc_type(acc_type), .priv(eff_priv), .mxr(mxr), .sum(sum),
    .xlate_on(xlate_on), .leaf_ok(leaf_ok), .pte_invalid(pte_invalid), .perm_ok(perm_ok)
  );
endmodule

// File: rtl/pte_guard_chk.sv
module pte_guard_chk #(
  parameter int SATP_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              satp_wr_en,
  input logic [SATP_W-1:0] satp_wr_data,
  input logic [SATP_W-1:0] satp_q,
  input logic [7:0]        pte_flags,
  input logic [1:0]        acc_type,
  input logic              is_fetch,
  input logic [1:0]        cur_priv,
  input logic              mprv,
  input logic [1:0]        mpp,
  input logic              mxr,
  input logic              sum,
  input logic [1:0]        eff_priv,
  input logic              xlate_on,
  input logic              pte_invalid,
  input logic              perm_ok
);
  // R1
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pte_flags[0] |-> pte_invalid);
  // R2
  fetch_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_fetch |-> eff_priv == cur_priv);
  // R3
  machine_bare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_priv == 2'd3 |-> !xlate_on);
  // R4
  refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (satp_wr_en && satp_wr_data[SATP_W-1 -: 4] == 4'd1) |=> $stable(satp_q));
  // R4
  accepted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (satp_wr_en && satp_wr_data[SATP_W-1 -: 4] == 4'd8) |=> satp_q == $past(satp_wr_data));
  // R6
  user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_on && eff_priv == 2'd0 && acc_type == 2'd1 && !(pte_flags[4] && pte_flags[2]))
      |-> !perm_ok);
  // R8
  sup_exec_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_on && eff_priv == 2'd1 && acc_type == 2'd2 && pte_flags[4]) |-> !perm_ok);
  // R10
  bare_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_on |-> perm_ok);
endmodule

bind pte_guard pte_guard_chk #(.SATP_W(SATP_W)) u_chk (.*);

// File: tb/pte_guard_bench.sv
`timescale 1ns/1ps
module pte_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        satp_wr_en = 1'b0;
  logic [63:0] satp_wr_data = '0;
  logic [63:0] satp_q;
  logic [7:0]  pte_flags = '0;
  logic [1:0]  acc_type = '0;
  logic        is_fetch = 1'b0;
  logic [1:0]  cur_priv = '0;
  logic        mprv = 1'b0;
  logic [1:0]  mpp = '0;
  logic        mxr = 1'b0;
  logic        sum = 1'b0;
  logic [1:0]  eff_priv;
  logic        xlate_on, pte_invalid, perm_ok;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] m_satp = '0;

  always #2.5 clk = ~clk;

  pte_guard u_pte_guard (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic want_ok(input logic [7:0] f, input logic [1:0] a,
                                   input logic [1:0] p, input logic x_on,
                                   input logic mx, input logic su);
    logic need;
    if (!x_on) return 1'b1;
    if (a == 2'd0) need = f[1] | (f[3] & mx);
    else if (a == 2'd1) need = f[2];
    else if (a == 2'd2) need = f[3];
    else return 1'b0;
    if (p == 2'd0) return f[4] & need;
    if (p == 2'd1) begin
      if (!f[4]) return need;
      if (a == 2'd2) return 1'b0;
      return su & need;
    end
    return 1'b0;
  endfunction

  function automatic string perm_tag(input logic [7:0] f, input logic [1:0] a,
                                     input logic [1:0] p, input logic x_on);
    if (!x_on || a == 2'd3) return "R10";
    if (p == 2'd0) return (a == 2'd0) ? "R5" : (a == 2'd1) ? "R6" : "R7";
    if (p == 2'd1) return f[4] ? "R8" : "R9";
    return "R10";
  endfunction

  task automatic apply(input logic [7:0] f, input logic [1:0] a, input logic fe,
                       input logic [1:0] cp, input logic mr, input logic [1:0] pp,
                       input logic mx, input logic su, input logic we,
                       input logic [63:0] wd);
    logic [1:0] ep;
    logic xo;
    @(negedge clk);
    pte_flags = f; acc_type = a; is_fetch = fe; cur_priv = cp; mprv = mr; mpp = pp;
    mxr = mx; sum = su; satp_wr_en = we; satp_wr_data = wd;
    #1;
    ep = (!fe && mr) ? pp : cp;
    xo = (ep != 2'd3) && (m_satp[63:60] == 4'd8);
    chk("R2", "eff_priv", {62'd0, eff_priv}, {62'd0, ep});
    chk("R3", "xlate_on", {63'd0, xlate_on}, {63'd0, xo});
    chk("R1", "pte_invalid", {63'd0, pte_invalid}, {63'd0, (!f[0]) || (f[2] && !f[1])});
    chk(perm_tag(f, a, ep, xo), "perm_ok", {63'd0, perm_ok},
        {63'd0, want_ok(f, a, ep, xo, mx, su)});
    @(posedge clk);
    #1;
    if (we && (wd[63:60] == 4'd0 || wd[63:60] == 4'd8)) m_satp = wd;
    chk("R4", "satp_q", satp_q, m_satp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] wd;
    logic [3:0]  md;
    logic [1:0]  cp;
    logic [1:0]  pp;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    #1;
    chk("R4", "reset satp_q", satp_q, 64'd0);
    rst_n = 1'b1;

    // R4 legalisation sequence, R3 bare before enabling
    apply(8'h13, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1, {4'd8, 60'h0_1234_5678_9abc_d});
    apply(8'h13, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1, {4'd1, 60'hfff});
    apply(8'h13, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1, {4'd9, 60'h55});
    apply(8'h13, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1, {4'd0, 60'h77});
    apply(8'h13, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 1, {4'd8, 60'h42});
    // R5 execute-only user page: read needs mxr
    apply(8'h19, 2'd0, 0, 2'd0, 0, 2'd0, 1, 0, 0, '0);
    apply(8'h19, 2'd0, 0, 2'd0, 0, 2'd0, 0, 0, 0, '0);
    // R8 supervisor execute of user page, even with sum
    apply(8'h1f, 2'd2, 1, 2'd1, 0, 2'd0, 0, 1, 0, '0);
    apply(8'h17, 2'd1, 0, 2'd1, 0, 2'd0, 0, 1, 0, '0);
    apply(8'h17, 2'd1, 0, 2'd1, 0, 2'd0, 0, 0, 0, '0);
    // R2 redirect for data, not for fetch
    apply(8'h1b, 2'd0, 0, 2'd3, 1, 2'd0, 0, 0, 0, '0);
    apply(8'h1b, 2'd2, 1, 2'd3, 1, 2'd0, 0, 0, 0, '0);
    // R1 write without read; R9 supervisor page
    apply(8'h05, 2'd1, 0, 2'd1, 0, 2'd0, 0, 0, 0, '0);
    apply(8'h0b, 2'd2, 1, 2'd1, 0, 2'd0, 0, 0, 0, '0);
    // R10 reserved access and privilege
    apply(8'hff, 2'd3, 0, 2'd0, 0, 2'd0, 1, 1, 0, '0);
    apply(8'hff, 2'd0, 0, 2'd2, 0, 2'd0, 1, 1, 0, '0);

    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 4))
        0: md = 4'd0;
        1: md = 4'd1;
        2, 3: md = 4'd8;
        default: md = 4'($urandom);
      endcase
      wd = {md, 28'($urandom), 32'($urandom)};
      cp = ($urandom_range(0, 9) == 0) ? 2'd2 : 2'($urandom_range(0, 1) == 0 ?
                                                   $urandom_range(0, 1) : 3);
      pp = 2'($urandom);
      apply(8'($urandom), 2'($urandom), 1'($urandom), cp, 1'($urandom), pp,
            1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0), wd);
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule